// File: doc/BRIEF.md
# Dual-Prescaler PWM Time Base

This block produces one pulse-width-modulated waveform and steers it onto two output pins. The input clock first passes through two cascaded dividers: a coarse stage that divides by a power of two, and a high-speed stage that divides by one or by an even number. Each pulse from the cascade is one time-base tick. A 16-bit counter advances on every tick, runs from zero up to one less than the programmed period, and then wraps back to zero.

The duty input is a fraction of the period, not a count. The block multiplies the duty by the period and shifts the product down to get the compare point. Each output is active while the counter is below that compare point. The output-select field chooses which pins carry the waveform. The polarity input sets which logic level is the active one.

All inputs are plain control levels and there is no handshake on any of them. Period and duty may be changed at any time. A new value is used only from the next counter wrap onward, so a change never cuts a PWM cycle short.

Top module: `pwm_timebase`

## Requirements
- R1: Coarse divider code `n` (3 bits) divides the input clock by 2^n, from /1 up to /128.
- R2: High-speed divider code `n` (3 bits) divides by 1 when `n` is 0 and by 2·n otherwise, giving /1, /2, /4 and so on up to /14.
- R3: The two stages are cascaded, so one tick occurs every (coarse ratio × high-speed ratio) enabled clocks. Any change in either divider code clears the prescaler count, and no tick is issued in the cycle the change is seen.
- R4: On each tick the counter steps by one. After reaching period−1 it wraps to 0, so one PWM cycle lasts `period` ticks. A period of 0 or 1 keeps the counter at 0. Between ticks the counter holds its value.
- R5: The compare point is (period × duty) >> 15, computed at 32 bits, so duty 0x8000 means 100%. An output is active while count < compare. A compare of 0 gives a constant inactive level. A compare at or above the period gives a constant active level.
- R6: New period and duty values take effect only when the counter wraps to 0. While the block is disabled they are loaded continuously.
- R7: Output select `sel[0]` enables pin A and `sel[1]` enables pin B, so 01 selects A only, 10 selects B only, 11 selects both, and 00 selects neither. When both are selected the two pins are identical.
- R8: With `pol`=0 the active level is 1. With `pol`=1 the active level is 0. The inactive level is always the value of `pol`.
- R9: While `en` is 0, both pins sit at the inactive level, the counter is 0 and the prescaler count is cleared.
- R10: During and right after reset the counter and the loaded period and compare are 0, so both pins show the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| coarse_div | input | 3 | Power-of-two divider code |
| hs_div | input | 3 | Even-step divider code |
| period | input | 16 | PWM period in ticks |
| duty | input | 16 | Relative duty, Q15 (0x8000 = 100%) |
| out_sel | input | 2 | Bit 0 enables pin A, bit 1 enables pin B |
| pol | input | 1 | Polarity: 1 makes the active level low |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bench changes a divider code in the middle of a run. A design that keeps the old prescaler count would then produce a tick early, and the waveform phase would drift from the reference. Period and duty are rewritten in the middle of a PWM cycle. A design that takes them immediately would produce a short or malformed pulse before the wrap. The bench also drives the compare extremes: duty 0, 0x8000, 0xFFFF and the product overflowing 16 bits. A compare truncated to the period width would wrap around and flicker instead of holding a steady level. Finally it covers period 0 and 1, the largest divider ratio, each select code under both polarities, and a disable in the middle of a run. Any of these errors shows up as a pin that differs from the reference on some clock.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  localparam int DIV_CODE_W = 3;
  localparam int NUM_PINS   = 2;

  typedef enum logic [1:0] {
    PIN_NONE = 2'b00,
    PIN_A    = 2'b01,
    PIN_B    = 2'b10,
    PIN_AB   = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int CW = pwm_tb_pkg::DIV_CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cdiv,
  input  logic [CW-1:0] hdiv,
  output logic          tick
);
  localparam int CCW = (1 << CW) - 1;  // coarse counter width (max 2^(2^CW-1)-1)
  localparam int HCW = CW + 1;         // high-speed counter width (max 2*(2^CW-1)-1)

  logic [CCW-1:0] c_q, c_lim;
  logic [HCW-1:0] h_q, h_lim;
  logic [CW-1:0]  cprev_q, hprev_q;
  logic           restart, c_wrap, h_wrap;

  always_comb begin
    c_lim   = CCW'((32'd1 << cdiv) - 32'd1);
    h_lim   = (hdiv == '0) ? '0 : ({hdiv, 1'b0} - HCW'(1));
    restart = (cdiv != cprev_q) || (hdiv != hprev_q);
    c_wrap  = (c_q >= c_lim);
    h_wrap  = (h_q >= h_lim);
    tick    = en && !restart && c_wrap && h_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q     <= '0;
      h_q     <= '0;
      cprev_q <= '0;
      hprev_q <= '0;
    end else begin
      cprev_q <= cdiv;
      hprev_q <= hdiv;
      if (!en || restart) begin
        c_q <= '0;
        h_q <= '0;
      end else if (c_wrap) begin
        c_q <= '0;
        h_q <= h_wrap ? '0 : h_q + HCW'(1);
      end else begin
        c_q <= c_q + CCW'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [PW-1:0] period,
  input  logic [DW-1:0] duty,
  output logic [PW-1:0] cnt_q,
  output logic [PW-1:0] per_q,
  output logic          active
);
  localparam int PRW = PW + DW;        // full product width
  localparam int CMW = PW + DW - 15;   // compare width, room for duty above 100%

  logic [PRW-1:0] prod;
  logic [CMW-1:0] cmp_new, cmp_q;
  logic           wrap;

  always_comb begin
    prod    = PRW'(period) * PRW'(duty);
    cmp_new = CMW'(prod >> (DW - 1));
    wrap    = (per_q <= PW'(1)) || (cnt_q >= per_q - PW'(1));
    active  = (CMW'(cnt_q) < cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
      per_q <= period;
      cmp_q <= cmp_new;
    end else if (tick) begin
      if (wrap) begin
        cnt_q <= '0;
        per_q <= period;
        cmp_q <= cmp_new;
      end else begin
        cnt_q <= cnt_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int NCH = pwm_tb_pkg::NUM_PINS
) (
  input  logic           en,
  input  logic           active,
  input  logic           pol,
  input  logic [NCH-1:0] sel,
  output logic [NCH-1:0] pins
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign pins[i] = (en && sel[i]) ? (active ^ pol) : pol;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = pwm_tb_pkg::DIV_CODE_W,
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] coarse_div,
  input  logic [CW-1:0] hs_div,
  input  logic [PW-1:0] period,
  input  logic [DW-1:0] duty,
  input  logic [1:0]    out_sel,
  input  logic          pol,
  output logic          pwm_a,
  output logic          pwm_b
);
  import pwm_tb_pkg::*;

  logic          tick;
  logic          active;
  logic [PW-1:0] cnt_q, per_q;
  logic [1:0]    pins;
  pin_sel_e      sel_e;

  assign sel_e = pin_sel_e'(out_sel);

  pwm_prescale #(.CW(CW)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cdiv(coarse_div), .hdiv(hs_div), .tick(tick)
  );

  pwm_period #(.PW(PW), .DW(DW)) u_per (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .period(period), .duty(duty),
    .cnt_q(cnt_q), .per_q(per_q), .active(active)
  );

  pwm_outstage #(.NCH(2)) u_out (
    .en(en), .active(active), .pol(pol), .sel(sel_e), .pins(pins)
  );

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pol,
  input logic [1:0]    out_sel,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic          tick,
  input logic [PW-1:0] cnt_q,
  input logic [PW-1:0] per_q
);
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < per_q));

  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> $stable(cnt_q));

  a_r6_period_held_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cnt_q != '0) |-> $stable(per_q));

  a_r7_both_pins_match: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 2'b11) |-> (pwm_a == pwm_b));

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_a == pol && pwm_b == pol));
endmodule

bind pwm_timebase pwm_timebase_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .out_sel(out_sel),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .tick(tick), .cnt_q(cnt_q), .per_q(per_q)
);

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  cdiv = '0;
  logic [2:0]  hdiv = '0;
  logic [15:0] period = '0;
  logic [15:0] duty = '0;
  logic [1:0]  sel = 2'b00;
  logic        pol = 1'b0;
  logic        pwm_a, pwm_b;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R10";
  bit    comparing = 1'b0;

  // reference model state
  int m_p, m_cnt, m_per, m_cmp, m_cprev, m_hprev, m_ratio;
  bit m_tick;

  always #2 clk = ~clk;  // 250 MHz

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .en(en), .coarse_div(cdiv), .hs_div(hdiv),
    .period(period), .duty(duty), .out_sel(sel), .pol(pol),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic int q15(int p, int d);
    longint pr;
    pr = longint'(p) * longint'(d);
    return int'(pr >>> 15);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_p = 0; m_cnt = 0; m_per = 0; m_cmp = 0; m_cprev = 0; m_hprev = 0;
    end else begin
      m_ratio = (1 << cdiv) * ((hdiv == 0) ? 1 : 2 * int'(hdiv));
      m_tick = 1'b0;
      if (!en || int'(cdiv) != m_cprev || int'(hdiv) != m_hprev) m_p = 0;
      else if (m_p == m_ratio - 1) begin m_tick = 1'b1; m_p = 0; end
      else m_p++;
      m_cprev = int'(cdiv);
      m_hprev = int'(hdiv);
      if (!en) begin
        m_cnt = 0; m_per = int'(period); m_cmp = q15(int'(period), int'(duty));
      end else if (m_tick) begin
        if (m_cnt + 1 >= m_per) begin
          m_cnt = 0; m_per = int'(period); m_cmp = q15(int'(period), int'(duty));
        end else m_cnt++;
      end
    end
  end

  task automatic check(string req, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %b exp %b at cycle %0d", req, what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && comparing) begin
      logic act, ea, eb;
      act = (m_cnt < m_cmp);
      ea  = (en && sel[0]) ? (act ^ pol) : pol;
      eb  = (en && sel[1]) ? (act ^ pol) : pol;
      check(cur_req, "pwm_a", pwm_a, ea);
      check(cur_req, "pwm_b", pwm_b, eb);
    end
  end

  task automatic setup(input logic e, input int c, input int h, input int p,
                       input int d, input logic [1:0] s, input logic pl);
    @(posedge clk); #1;
    en = e; cdiv = 3'(c); hdiv = 3'(h); period = 16'(p); duty = 16'(d);
    sel = s; pol = pl;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic count_high(input int n, input int exp, input string req);
    int hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_a) hi++;
    end
    n_chk++;
    if (hi != exp) begin
      n_bad++;
      $display("FAIL %s high-count got %0d exp %0d", req, hi, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "pwm_a in reset", pwm_a, 1'b0);
    check("R10", "pwm_b in reset", pwm_b, 1'b0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10", "pwm_a after reset", pwm_a, 1'b0);
    check("R10", "pwm_b after reset", pwm_b, 1'b0);
    comparing = 1'b1;

    // R1/R5: undivided clock, period 10, 50% duty
    cur_req = "R5";
    setup(1, 0, 0, 10, 16'h4000, 2'b11, 0);
    run(30);
    count_high(100, 50, "R5");

    // R3: /4 * /6 = 24 clocks per tick, period 5, compare 3
    cur_req = "R3";
    setup(1, 2, 3, 5, 16'h6000, 2'b11, 0);
    run(300);
    count_high(240, 144, "R3");

    // R2/R3: high-speed code changed mid-run restarts the prescaler
    cur_req = "R2";
    setup(1, 2, 1, 5, 16'h6000, 2'b11, 0);
    run(250);
    setup(1, 1, 5, 7, 16'h2000, 2'b01, 0);
    run(300);

    // R1: largest ratio 128*14
    cur_req = "R1";
    setup(1, 7, 7, 2, 16'h4000, 2'b11, 0);
    run(7500);

    // R5: compare extremes
    cur_req = "R5";
    setup(1, 0, 1, 6, 16'h0000, 2'b11, 0);
    run(60);
    setup(1, 0, 1, 6, 16'h8000, 2'b11, 0);
    run(60);
    setup(1, 0, 1, 40000, 16'hFFFF, 2'b11, 0);
    run(80);
    setup(1, 0, 0, 9, 16'h5555, 2'b11, 0);
    run(60);

    // R6: period and duty rewritten mid-cycle
    cur_req = "R6";
    setup(1, 1, 0, 12, 16'h4000, 2'b11, 0);
    run(50);
    setup(1, 1, 0, 20, 16'h6000, 2'b11, 0);
    run(7);
    setup(1, 1, 0, 4, 16'h2000, 2'b11, 0);
    run(90);

    // R7/R8: select codes under both polarities
    for (int pl = 0; pl < 2; pl++) begin
      for (int s = 0; s < 4; s++) begin
        cur_req = (pl == 0) ? "R7" : "R8";
        setup(1, 0, 2, 7, 16'h3000, 2'(s), 1'(pl));
        run(40);
      end
    end

    // R9: disable mid-run, re-enable
    cur_req = "R9";
    setup(1, 1, 1, 8, 16'h4000, 2'b11, 1);
    run(23);
    setup(0, 1, 1, 8, 16'h4000, 2'b11, 1);
    run(20);
    setup(1, 1, 1, 8, 16'h4000, 2'b11, 1);
    run(50);

    // R4: degenerate periods
    cur_req = "R4";
    setup(1, 0, 0, 0, 16'h8000, 2'b11, 0);
    run(20);
    setup(1, 0, 0, 1, 16'h4000, 2'b11, 0);
    run(20);
    setup(1, 0, 0, 1, 16'h8000, 2'b11, 0);
    run(20);
    setup(1, 0, 0, 3, 16'h5556, 2'b11, 0);
    run(30);

    comparing = 1'b0;
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end
endmodule